// File: doc/BRIEF.md
# Doubleword Shift and Rotate Unit

This block is a purely combinational shifter for a 64-bit integer datapath. It performs four kinds of shift: logical left, logical right, arithmetic right and rotate right. It decodes a 4-bit operation code and forms the result in the same cycle as its inputs.

Each kind comes in three forms. The immediate form shifts the first operand by a 5-bit amount. The high form shifts the first operand by the immediate plus half the data width, which reaches amounts 32 to 63. The variable form shifts the second operand by the low six bits of the first operand.

The unit sits between operand read and result write-back. It has no clock or reset of its own. Any pipelining belongs to the surrounding datapath.

Top module: `shf64_unit`

## Requirements
- R1: Code 0 gives opnd_a_i shifted left by imm_i, with zeros shifted into the low bits.
- R2: The high forms shift opnd_a_i by imm_i+32. These are code 1 (left), code 4 (logical right), code 7 (arithmetic right) and code 10 (rotate right).
- R3: The variable forms shift opnd_b_i by opnd_a_i[5:0], and bits [63:6] of opnd_a_i have no effect. These are code 2 (left), code 5 (logical right), code 8 (arithmetic right) and code 11 (rotate right).
- R4: Code 3 gives opnd_a_i shifted right by imm_i, with zeros shifted into the high bits.
- R5: Code 6 gives opnd_a_i shifted right by imm_i, with copies of bit 63 shifted into the high bits.
- R6: Code 9 gives opnd_a_i rotated right by imm_i. A rotate by n equals (x >> n) | (x << (64-n)).
- R7: A rotate by a total amount of zero returns the value unchanged. This holds for the immediate form, and for the variable form even when the upper operand bits are set.
- R8: Codes 12 to 15 give a result of zero.
- R9: The result follows the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| opnd_a_i | input | 64 | First operand: the value in the immediate and high forms, the amount in the variable forms |
| opnd_b_i | input | 64 | Second operand: the value in the variable forms |
| imm_i | input | 5 | Immediate shift amount |
| res_o | output | 64 | Result |

## Verification
The bench builds the unit with its defaults: 64-bit data and a 5-bit immediate. With these values the high forms cover amounts 32 to 63, so every operation is driven at all 64 shift amounts against a reference function.

Random values are mixed with sign-set and all-ones patterns. In the variable forms, random upper amount bits show that only the low six bits count. Directed cases cover a rotate by zero with dirty upper amount bits, a full-width arithmetic fill, and the unused codes.

// File: rtl/shf64_pkg.sv
package shf64_pkg;
  typedef enum logic [3:0] {
    OP_SLL    = 4'd0,
    OP_SLL_HI = 4'd1,
    OP_SLL_V  = 4'd2,
    OP_SRL    = 4'd3,
    OP_SRL_HI = 4'd4,
    OP_SRL_V  = 4'd5,
    OP_SRA    = 4'd6,
    OP_SRA_HI = 4'd7,
    OP_SRA_V  = 4'd8,
    OP_ROR    = 4'd9,
    OP_ROR_HI = 4'd10,
    OP_ROR_V  = 4'd11
  } shf_op_e;

  typedef enum logic [1:0] {
    KIND_SLL = 2'd0,
    KIND_SRL = 2'd1,
    KIND_SRA = 2'd2,
    KIND_ROR = 2'd3
  } shf_kind_e;

  typedef enum logic [1:0] {
    FORM_IMM = 2'd0,
    FORM_HI  = 2'd1,
    FORM_VAR = 2'd2
  } shf_form_e;
endpackage

// File: rtl/shf_amt_sel.sv
module shf_amt_sel
  import shf64_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] val_o,
  output logic [AMT_W-1:0]  amt_o,
  output shf_kind_e         kind_o,
  output logic              valid_o
);
  localparam int HI_OFS = DATA_W / 2;

  shf_form_e form;
  logic [AMT_W-1:0] imm_ext;

  assign imm_ext = AMT_W'(imm_i);

  always_comb begin
    valid_o = 1'b1;
    kind_o  = KIND_SLL;
    form    = FORM_IMM;
    case (op_i)
      OP_SLL:    begin kind_o = KIND_SLL; form = FORM_IMM; end
      OP_SLL_HI: begin kind_o = KIND_SLL; form = FORM_HI;  end
      OP_SLL_V:  begin kind_o = KIND_SLL; form = FORM_VAR; end
      OP_SRL:    begin kind_o = KIND_SRL; form = FORM_IMM; end
      OP_SRL_HI: begin kind_o = KIND_SRL; form = FORM_HI;  end
      OP_SRL_V:  begin kind_o = KIND_SRL; form = FORM_VAR; end
      OP_SRA:    begin kind_o = KIND_SRA; form = FORM_IMM; end
      OP_SRA_HI: begin kind_o = KIND_SRA; form = FORM_HI;  end
      OP_SRA_V:  begin kind_o = KIND_SRA; form = FORM_VAR; end
      OP_ROR:    begin kind_o = KIND_ROR; form = FORM_IMM; end
      OP_ROR_HI: begin kind_o = KIND_ROR; form = FORM_HI;  end
      OP_ROR_V:  begin kind_o = KIND_ROR; form = FORM_VAR; end
      default:   valid_o = 1'b0;
    endcase
  end

  always_comb begin
    case (form)
      FORM_HI: begin
        val_o = opnd_a_i;
        amt_o = imm_ext + AMT_W'(HI_OFS);
      end
      FORM_VAR: begin
        // value from second operand, amount from low bits of first
        val_o = opnd_b_i;
        amt_o = opnd_a_i[AMT_W-1:0];
      end
      default: begin
        val_o = opnd_a_i;
        amt_o = imm_ext;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, imm_i}) && valid_o && form == FORM_HI)
      assert_hi_amt_R2: assert (amt_o >= AMT_W'(HI_OFS))
        else $error("high form amount below offset");
  end
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf64_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  shf_kind_e         kind_i,
  output logic [DATA_W-1:0] res_o
);
  logic                      go_left;
  logic                      is_rot;
  logic                      fill_bit;
  logic [DATA_W-1:0]         val_rev;
  logic [DATA_W-1:0]         out_rev;
  logic [AMT_W:0][DATA_W-1:0] stg;

  assign go_left  = (kind_i == KIND_SLL);
  assign is_rot   = (kind_i == KIND_ROR);
  assign fill_bit = (kind_i == KIND_SRA) & val_i[DATA_W-1];

  // left shift runs through the right shifter on bit-reversed data
  always_comb begin
    for (int i = 0; i < DATA_W; i++) val_rev[i] = val_i[DATA_W-1-i];
  end

  assign stg[0] = go_left ? val_rev : val_i;

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [DATA_W-1:0] moved;
    assign moved = is_rot ? {stg[k][SH-1:0], stg[k][DATA_W-1:SH]}
                          : {{SH{fill_bit}}, stg[k][DATA_W-1:SH]};
    assign stg[k+1] = amt_i[k] ? moved : stg[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) out_rev[i] = stg[AMT_W][DATA_W-1-i];
  end

  assign res_o = go_left ? out_rev : stg[AMT_W];

  always_comb begin
    if (!$isunknown({val_i, amt_i, kind_i})) begin
      if (is_rot && amt_i == '0)
        assert_rot_zero_R7: assert (res_o == val_i)
          else $error("rotate by zero altered value");
      if (is_rot)
        assert_rot_bits_R6: assert ($countones(res_o) == $countones(val_i))
          else $error("rotate changed bit count");
      if (kind_i == KIND_SRA)
        assert_sra_sign_R5: assert (res_o[DATA_W-1] == val_i[DATA_W-1])
          else $error("arithmetic shift lost sign");
      if (kind_i == KIND_SRL && amt_i != '0)
        assert_srl_zero_R4: assert (res_o[DATA_W-1] == 1'b0)
          else $error("logical right shift filled non-zero");
      if (go_left && amt_i != '0)
        assert_sll_zero_R1: assert (res_o[0] == 1'b0)
          else $error("left shift filled non-zero");
    end
  end
endmodule

// File: rtl/shf64_unit.sv
module shf64_unit
  import shf64_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 5
) (
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sel_val;
  logic [AMT_W-1:0]  sel_amt;
  shf_kind_e         sel_kind;
  logic              sel_valid;
  logic [DATA_W-1:0] core_res;

  shf_amt_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_sel (
    .op_i     (op_i),
    .opnd_a_i (opnd_a_i),
    .opnd_b_i (opnd_b_i),
    .imm_i    (imm_i),
    .val_o    (sel_val),
    .amt_o    (sel_amt),
    .kind_o   (sel_kind),
    .valid_o  (sel_valid)
  );

  shf_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_core (
    .val_i  (sel_val),
    .amt_i  (sel_amt),
    .kind_i (sel_kind),
    .res_o  (core_res)
  );

  assign res_o = sel_valid ? core_res : '0;

  always_comb begin
    if (!$isunknown({op_i, opnd_a_i, opnd_b_i, imm_i})) begin
      if (op_i >= 4'd12)
        assert_unused_zero_R8: assert (res_o == '0)
          else $error("unused code gave non-zero");
      if (op_i == OP_SRL_HI)
        assert_srl_hi_upper_R2: assert (res_o[DATA_W-1:DATA_W/2] == '0)
          else $error("high logical right left upper bits");
      if (op_i == OP_ROR_V && opnd_a_i[AMT_W-1:0] == '0)
        assert_rotv_zero_R3: assert (res_o == opnd_b_i)
          else $error("variable rotate by zero altered value");
    end
  end
endmodule

// File: tb/shf64_unit_tb.sv
`timescale 1ns/1ps
module shf64_unit_tb;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [63:0] a, b;
  logic [4:0]  imm;
  logic [63:0] res;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  shf64_unit u_dut (
    .op_i(op), .opnd_a_i(a), .opnd_b_i(b), .imm_i(imm), .res_o(res)
  );

  function automatic logic [63:0] ref_f(int o, logic [63:0] x, logic [63:0] y, logic [4:0] im);
    logic [63:0] v;
    int n;
    if (o >= 12) return 64'd0;
    case (o % 3)
      0: begin v = x; n = int'(im); end
      1: begin v = x; n = int'(im) + 32; end
      default: begin v = y; n = int'(x[5:0]); end
    endcase
    case (o / 3)
      0: return v << n;
      1: return v >> n;
      2: return 64'($signed(v) >>> n);
      default: return (n == 0) ? v : ((v >> n) | (v << (64 - n)));
    endcase
  endfunction

  function automatic string req_of(int o, int n);
    if (o >= 12) return "R8";
    if (o / 3 == 3 && n == 0) return "R7";
    if (o % 3 == 1) return "R2";
    if (o % 3 == 2) return "R3";
    case (o / 3)
      0: return "R1";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // drive at negedge, sample 1 ns later with no clock edge between: R9
  task automatic apply(int o, logic [63:0] x, logic [63:0] y, logic [4:0] im, string rq);
    logic [63:0] exp;
    @(negedge clk);
    op = 4'(o); a = x; b = y; imm = im;
    #1;
    exp = ref_f(o, x, y, im);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%0d actual=%h expected=%h",
               rq, o, x, y, im, res, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y;
    void'($urandom(32'd1234));
    op = '0; a = '0; b = '0; imm = '0;
    // idle inputs: code 0 on zero operands gives zero (R1)
    apply(0, 64'd0, 64'd0, 5'd0, "R1");

    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 64; n++) begin
        x = {$urandom, $urandom};
        y = {$urandom, $urandom};
        if (n % 8 == 3) x[63] = 1'b1;
        if (n % 8 == 5) y[63] = 1'b1;
        if (n % 16 == 7) begin x = '1; y = '1; end
        if (o % 3 == 2) x[5:0] = 6'(n); // upper bits of x stay random: R3
        apply(o, x, y, 5'(n % 32), req_of(o, (o % 3 == 1) ? n % 32 + 32 : ((o % 3 == 2) ? n : n % 32)));
      end
    end

    // directed corners
    apply(9,  64'h0123_4567_89AB_CDEF, 64'd0, 5'd0, "R7");
    apply(11, 64'hFFFF_FFFF_FFFF_FFC0, 64'hDEAD_BEEF_0BAD_F00D, 5'd17, "R7");
    apply(8,  64'h0000_0000_0000_003F, 64'h8000_0000_0000_0000, 5'd0, "R5");
    apply(7,  64'h8000_0000_0000_0000, 64'd0, 5'd31, "R2");
    apply(5,  64'hFFFF_FFFF_FFFF_FF80, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0, "R3");
    apply(10, 64'h8000_0000_0000_0001, 64'd0, 5'd31, "R2");
    apply(15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'd31, "R8");
    apply(3,  64'h8000_0000_0000_0000, 64'd0, 5'd31, "R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule